// File: doc/BRIEF.md
# Transmit Dominant Time-out Guard

This block sits between the transmit data line coming from a microcontroller and the enable of a single-wire bus driver. A low level on the transmit line asks the driver to pull the bus dominant; a high level leaves the driver off so the bus rests recessive. The guard lets that command through while communication is enabled. It also watches how long the transmit line has been held low without a break. A line stuck low would otherwise hold the whole bus dominant forever.

When the line has stayed low for a parameterised number of clock cycles, the guard trips. It forces the driver recessive and raises a status flag. Release does not come on the first rising edge. The transmit line must stay high for a second parameterised number of consecutive cycles, and only then are the flag and the block cleared. The transmit input is assumed to be already synchronised to the clock. Both durations are given in clock cycles, so the integrator scales them from the clock frequency. Typical targets are a time-out in the 4 ms to 20 ms range and a recovery time just above 10 µs.

Top module: `txd_dom_guard`

## Requirements
- R1: While `txd` is 1 (recessive request), `drv_dom` is 0.
- R2: While `comm_en` is 0, `drv_dom` is 0 whatever `txd` is.
- R3: While the guard is not tripped, `drv_dom` equals `comm_en & ~txd` in the same cycle (combinational path, no added latency).
- R4: `tripped` rises right after the clock edge that samples `txd` = 0 for the TIMEOUT_CYC-th consecutive time. A run of TIMEOUT_CYC-1 low samples followed by a high sample does not trip.
- R5: While `tripped` is 1, `drv_dom` is 0 and `tripped` stays 1 for as long as `txd` is sampled 0.
- R6: A tripped guard clears `tripped` right after the edge that samples `txd` = 1 for the RECOVER_CYC-th consecutive time.
- R7: During recovery, a high pulse shorter than RECOVER_CYC samples followed by a low sample restarts the recovery count and leaves the guard tripped.
- R8: Every high sample of `txd` restarts the dominant count from zero, and the count is also zero right after a release. A fresh trip therefore needs a full TIMEOUT_CYC low run.
- R9: After reset (`rst_n` low, active-low, asynchronous), `tripped` is 0 and both counts are zero.
- R10: The dominant time-out keeps counting while `comm_en` is 0. A line held low during a disabled period trips the guard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| comm_en | input | 1 | Communication enable from the mode controller (1 = normal mode) |
| txd | input | 1 | Synchronised transmit data, 0 = drive dominant |
| drv_dom | output | 1 | Driver command, 1 = pull bus dominant |
| tripped | output | 1 | Time-out status, 1 while the guard holds the driver off |

## Verification
The bench targets the off-by-one limits on both counters:
- A low run one sample short of the time-out must not trip, where a design that counts from one instead of zero would trip early.
- A high pulse one sample short of recovery followed by a low sample must keep the guard tripped, where a design that releases on the first rising edge or keeps a partial count would let the driver loose.
- Back-to-back low runs split by a single high sample must not trip, where a design that fails to clear the count on a rising edge would add the runs together.
- A stuck-low line during a disabled period must still trip, where a design that gates the timer with the enable would hand a stuck line to the driver as soon as normal mode returns.

// File: rtl/tdg_pkg.sv
package tdg_pkg;

  typedef enum logic {
    GUARD_ARMED   = 1'b0,
    GUARD_TRIPPED = 1'b1
  } guard_state_e;

  function automatic int cnt_width(input int limit);
    int w;
    w = 1;
    while ((1 << w) < limit) w++;
    return w;
  endfunction

endpackage

// File: rtl/tdg_run_counter.sv
module tdg_run_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic hit,
  output logic done
);
  localparam int W = tdg_pkg::cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] run_q;

  assign done = hit && !clear && (run_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (clear || !hit || done) begin
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/tdg_trip_state.sv
module tdg_trip_state
  import tdg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_trip,
  input  logic clr_trip,
  output logic is_tripped
);
  guard_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GUARD_ARMED:   if (set_trip) state_d = GUARD_TRIPPED;
      GUARD_TRIPPED: if (clr_trip) state_d = GUARD_ARMED;
      default:       state_d = GUARD_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GUARD_ARMED;
    else        state_q <= state_d;
  end

  assign is_tripped = (state_q == GUARD_TRIPPED);
endmodule

// File: rtl/tdg_drive_gate.sv
module tdg_drive_gate (
  input  logic enable,
  input  logic tx_level,
  input  logic hold_off,
  output logic pull_dom
);
  always_comb begin
    pull_dom = 1'b0;
    if (enable && !hold_off && !tx_level) pull_dom = 1'b1;
  end
endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard #(
  parameter int TIMEOUT_CYC = 1000000,
  parameter int RECOVER_CYC = 1100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic comm_en,
  input  logic txd,
  output logic drv_dom,
  output logic tripped
);
  logic low_done;
  logic high_done;
  logic trip_q;

  // Dominant run: counts consecutive low samples while armed.
  tdg_run_counter #(.LIMIT(TIMEOUT_CYC)) u_low_run (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (trip_q),
    .hit   (!txd),
    .done  (low_done)
  );

  // Recovery run: counts consecutive high samples while tripped.
  tdg_run_counter #(.LIMIT(RECOVER_CYC)) u_high_run (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!trip_q),
    .hit   (txd),
    .done  (high_done)
  );

  tdg_trip_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_trip   (low_done),
    .clr_trip   (high_done),
    .is_tripped (trip_q)
  );

  tdg_drive_gate u_gate (
    .enable   (comm_en),
    .tx_level (txd),
    .hold_off (trip_q),
    .pull_dom (drv_dom)
  );

  assign tripped = trip_q;
endmodule

// File: rtl/txd_dom_guard_chk.sv
module txd_dom_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic comm_en,
  input logic txd,
  input logic drv_dom,
  input logic tripped
);
  a_r1_high_is_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    txd |-> !drv_dom);

  a_r2_disabled_is_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    !comm_en |-> !drv_dom);

  a_r5_tripped_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |-> !drv_dom);

  a_r5_low_keeps_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && !txd) |=> tripped);

  a_r4_high_never_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (!tripped && txd) |=> !tripped);

  a_r6_release_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tripped) |-> $past(txd));

  a_r4_trip_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tripped) |-> $past(!txd));
endmodule

bind txd_dom_guard txd_dom_guard_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .comm_en (comm_en),
  .txd     (txd),
  .drv_dom (drv_dom),
  .tripped (tripped)
);

// File: tb/txd_dom_guard_test.sv
`timescale 1ns/1ps
module txd_dom_guard_test;
  localparam int TO = 20;
  localparam int RC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic comm_en = 1'b0;
  logic txd = 1'b1;
  logic drv_dom;
  logic tripped;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int lowrun = 0;
  int highrun = 0;
  bit mtrip = 1'b0;

  always #5 clk = ~clk;

  txd_dom_guard #(.TIMEOUT_CYC(TO), .RECOVER_CYC(RC)) uut (
    .clk(clk), .rst_n(rst_n), .comm_en(comm_en), .txd(txd),
    .drv_dom(drv_dom), .tripped(tripped)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drive one cycle of inputs at a falling edge, advance the model at the
  // rising edge, compare at the next falling edge.
  task automatic step(input string req, input logic en, input logic t);
    comm_en = en;
    txd = t;
    @(posedge clk);
    if (!mtrip) begin
      if (!t) lowrun++; else lowrun = 0;
      if (lowrun >= TO) begin mtrip = 1'b1; highrun = 0; end
    end else begin
      if (t) highrun++; else highrun = 0;
      if (highrun >= RC) begin mtrip = 1'b0; lowrun = 0; end
    end
    @(negedge clk);
    check(req, tripped, mtrip, "tripped");
    check(req, drv_dom, en & ~t & ~mtrip, "drv_dom");
  endtask

  task automatic run(input string req, input logic en, input logic t, input int n);
    for (int i = 0; i < n; i++) step(req, en, t);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R9", tripped, 1'b0, "tripped in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", tripped, 1'b0, "tripped after reset");
    check("R9", drv_dom, 1'b0, "drv_dom after reset");

    // R3 / R1: ordinary bit pattern while enabled
    for (int i = 0; i < 16; i++) step("R3", 1'b1, logic'((i * 5 + 1) % 3 == 0));
    run("R1", 1'b1, 1'b1, 3);
    // R2: disabled, short low burst
    run("R2", 1'b0, 1'b0, 4);
    run("R2", 1'b0, 1'b1, 2);

    // R4: one short of time-out, then high: no trip
    run("R4", 1'b1, 1'b0, TO - 1);
    check("R4", tripped, 1'b0, "no trip at TO-1");
    step("R4", 1'b1, 1'b1);
    // R4: full run trips
    run("R4", 1'b1, 1'b0, TO);
    check("R4", tripped, 1'b1, "trip at TO");
    // R5: held low while tripped
    run("R5", 1'b1, 1'b0, 10);

    // R7: short high pulse then low: stays tripped
    run("R7", 1'b1, 1'b1, RC - 1);
    step("R7", 1'b1, 1'b0);
    check("R7", tripped, 1'b1, "still tripped after short pulse");
    run("R7", 1'b1, 1'b1, RC - 1);
    check("R7", tripped, 1'b1, "count restarted");
    // R6: final sample completes recovery
    step("R6", 1'b1, 1'b1);
    check("R6", tripped, 1'b0, "released at RC");

    // R8: split low runs do not add up
    run("R8", 1'b1, 1'b0, TO - 1);
    step("R8", 1'b1, 1'b1);
    run("R8", 1'b1, 1'b0, TO - 1);
    check("R8", tripped, 1'b0, "split runs no trip");
    step("R8", 1'b1, 1'b1);

    // R10: stuck low while disabled still trips
    run("R10", 1'b0, 1'b0, TO + 3);
    check("R10", tripped, 1'b1, "trip while disabled");
    step("R10", 1'b1, 1'b0);
    check("R10", drv_dom, 1'b0, "re-enabled stuck line held off");
    run("R6", 1'b1, 1'b1, RC + 2);
    run("R3", 1'b1, 1'b0, 3);
    check("R3", drv_dom, 1'b1, "dominant after recovery");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule